// File: doc/BRIEF.md
# Reference Clock Validity Monitor

This block turns the quality alarms reported for each reference clock input into one registered validity bit per input. An input counts as valid only while none of its alarms is active. Two further conditions apply only when configuration enables them. One checks that the input's edges stay inside the narrow drift window for low-rate inputs. The other checks that the currently selected input has not lost two or more consecutive cycles. The detectors that produce the alarms sit outside this block, and their results arrive here as plain inputs.

Every change of an input's validity sets a sticky change flag for that input. A separate sticky flag records a failure of the currently selected reference, meaning its validity falls from valid to invalid. Software clears each flag by pulsing a write-one-to-clear strobe. The interrupt line is the OR of the flags whose mask bit is set. The selected-reference failure can also be routed to a status pin, which stays high until that flag is cleared.

Top module: `refclk_health_mon`

## Requirements
- R1: `valid_o[i]` is 1 in the cycle after a clock edge only if, at that edge, `noact_alarm_i[i]`, `freq_alarm_i[i]` and `phase_alarm_i[i]` were all 0; with all gated conditions passing, it is 1 whenever all three were 0.
- R2: When `noise_chk_en_i` is 1, `noise_viol_i[i]` = 1 forces input i invalid on the next edge. When it is 0, `noise_viol_i` has no effect on `valid_o`.
- R3: When `fast_sw_en_i` is 1 and `miss_cnt_i` >= 2, the input whose index equals `sel_idx_i` becomes invalid on the next edge. A count of 0 or 1 keeps it valid, other inputs are never affected, and with `fast_sw_en_i` = 0 the count has no effect.
- R4: Any change of `valid_o[i]`, from 0 to 1 or from 1 to 0, sets `chg_flag_o[i]` on the same edge. The flag stays set until an edge where `chg_clr_i[i]` is 1.
- R5: `fail_flag_o` is set on the edge where the input indexed by `sel_idx_i` goes from valid to invalid. It is not set when that input recovers, and it is not set by changes on other inputs. It stays set until an edge where `fail_clr_i` is 1.
- R6: `irq_o` is 1 exactly when some `chg_flag_o[i]` with `chg_mask_i[i]` = 1 is set, or when `fail_flag_o` is set with `fail_mask_i` = 1.
- R7: `stat_pin_o` is 1 exactly when `pin_route_en_i`, `fail_mask_i` and `fail_flag_o` are all 1. Once high, it remains high until the failure flag is cleared.
- R8: When a clear strobe and a new event for the same flag arrive on the same edge, the flag ends set.
- R9: During reset, all validity bits, flags, `irq_o` and `stat_pin_o` are 0. Every input leaves reset invalid, so the first edge at which an input qualifies also sets its change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| noact_alarm_i | input | N_REF | Per-input no-activity alarm |
| freq_alarm_i | input | N_REF | Per-input hard frequency alarm |
| phase_alarm_i | input | N_REF | Per-input phase lock alarm |
| noise_viol_i | input | N_REF | Per-input edge drift outside the narrow window |
| miss_cnt_i | input | MISS_W | Consecutive missed cycles of the selected input |
| noise_chk_en_i | input | 1 | Enables the drift-window condition |
| fast_sw_en_i | input | 1 | Enables the missed-cycle condition |
| sel_idx_i | input | IDX_W | Index of the currently selected input |
| chg_mask_i | input | N_REF | Interrupt enable for each change flag |
| fail_mask_i | input | 1 | Interrupt enable for the failure flag |
| pin_route_en_i | input | 1 | Routes the failure interrupt to the status pin |
| chg_clr_i | input | N_REF | Write-one-to-clear strobes for the change flags |
| fail_clr_i | input | 1 | Write-one-to-clear strobe for the failure flag |
| valid_o | output | N_REF | Registered validity per input |
| chg_flag_o | output | N_REF | Sticky validity-change flags |
| fail_flag_o | output | 1 | Sticky selected-reference failure flag |
| irq_o | output | 1 | Interrupt, OR of the enabled flags |
| stat_pin_o | output | 1 | Status pin for the failure interrupt |

## Verification
The assertions assume the following about the inputs:
- The alarm, count and selection inputs are stable across each sampling edge.
- `sel_idx_i` names an input that exists.
- `miss_cnt_i` already saturates at its width, so the `>= 2` comparison is meaningful.

The stimulus meets these assumptions. It changes every input one time unit after a rising edge, it only uses indices below the input count, and it keeps the missed-cycle count in the range 0 to 3 of a 3-bit field. The assertions also depend on the selection not moving during the cycle in which a failure is taken. The bench keeps `sel_idx_i` fixed around every failure it provokes.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    // Missed-cycle count at which the selected input is disqualified.
    localparam int unsigned FAST_MISS_LIMIT = 2;

    // Next value of a sticky bit; an event in the clearing cycle wins.
    function automatic logic sticky_next(input logic q, input logic clr, input logic evt);
        return (q & ~clr) | evt;
    endfunction

endpackage

// File: rtl/refmon_qualify.sv
module refmon_qualify #(
    parameter int unsigned N_REF  = 8,
    parameter int unsigned MISS_W = 4,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [N_REF-1:0]  noact_i,
    input  logic [N_REF-1:0]  freq_i,
    input  logic [N_REF-1:0]  phase_i,
    input  logic [N_REF-1:0]  noise_i,
    input  logic [MISS_W-1:0] miss_cnt_i,
    input  logic              noise_en_i,
    input  logic              fast_en_i,
    input  logic [IDX_W-1:0]  sel_i,
    output logic [N_REF-1:0]  ok_o
);
    localparam logic [MISS_W-1:0] MISS_LIM = MISS_W'(refmon_pkg::FAST_MISS_LIMIT);

    logic miss_over;
    assign miss_over = fast_en_i && (miss_cnt_i >= MISS_LIM);

    for (genvar i = 0; i < N_REF; i++) begin : g_in
        logic sel_hit;
        logic hard_bad;
        logic gated_bad;
        assign sel_hit   = (sel_i == IDX_W'(i));
        assign hard_bad  = noact_i[i] | freq_i[i] | phase_i[i];
        assign gated_bad = (noise_en_i & noise_i[i]) | (sel_hit & miss_over);
        assign ok_o[i]   = ~(hard_bad | gated_bad);
    end
endmodule

// File: rtl/refmon_sticky.sv
module refmon_sticky #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] flag_d, flag_q;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            flag_d[i] = refmon_pkg::sticky_next(flag_q[i], clr_i[i], evt_i[i]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R4
        sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        // R8
        event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/refclk_health_mon.sv
module refclk_health_mon #(
    parameter int unsigned N_REF  = 8,
    parameter int unsigned MISS_W = 4,
    parameter int unsigned IDX_W  = (N_REF > 1) ? $clog2(N_REF) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_REF-1:0]  noact_alarm_i,
    input  logic [N_REF-1:0]  freq_alarm_i,
    input  logic [N_REF-1:0]  phase_alarm_i,
    input  logic [N_REF-1:0]  noise_viol_i,
    input  logic [MISS_W-1:0] miss_cnt_i,
    input  logic              noise_chk_en_i,
    input  logic              fast_sw_en_i,
    input  logic [IDX_W-1:0]  sel_idx_i,
    input  logic [N_REF-1:0]  chg_mask_i,
    input  logic              fail_mask_i,
    input  logic              pin_route_en_i,
    input  logic [N_REF-1:0]  chg_clr_i,
    input  logic              fail_clr_i,
    output logic [N_REF-1:0]  valid_o,
    output logic [N_REF-1:0]  chg_flag_o,
    output logic              fail_flag_o,
    output logic              irq_o,
    output logic              stat_pin_o
);
    localparam logic [MISS_W-1:0] MISS_LIM = MISS_W'(refmon_pkg::FAST_MISS_LIMIT);

    typedef struct packed {
        logic [N_REF-1:0] valid;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic [N_REF-1:0] ok_now;
    logic [N_REF-1:0] chg_evt;
    logic             sel_valid_q;
    logic             sel_ok_now;
    logic             fail_evt;
    logic [0:0]       fail_flag_v;

    refmon_qualify #(
        .N_REF (N_REF),
        .MISS_W(MISS_W),
        .IDX_W (IDX_W)
    ) u_qual (
        .noact_i   (noact_alarm_i),
        .freq_i    (freq_alarm_i),
        .phase_i   (phase_alarm_i),
        .noise_i   (noise_viol_i),
        .miss_cnt_i(miss_cnt_i),
        .noise_en_i(noise_chk_en_i),
        .fast_en_i (fast_sw_en_i),
        .sel_i     (sel_idx_i),
        .ok_o      (ok_now)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = ok_now;
        chg_evt    = st_q.valid ^ ok_now;
        sel_valid_q = 1'b0;
        sel_ok_now  = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (sel_idx_i == IDX_W'(i)) begin
                sel_valid_q = st_q.valid[i];
                sel_ok_now  = ok_now[i];
            end
        end
        fail_evt = sel_valid_q & ~sel_ok_now;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar i = 0; i < N_REF; i++) begin : g_vchk
        // R1
        alarm_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            st_q.valid[i] |-> $past(!noact_alarm_i[i] && !freq_alarm_i[i] && !phase_alarm_i[i]));
        // R2
        noise_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (noise_chk_en_i && noise_viol_i[i]) |=> !st_q.valid[i]);
        // R3
        miss_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fast_sw_en_i && (sel_idx_i == IDX_W'(i)) && (miss_cnt_i >= MISS_LIM)) |=> !st_q.valid[i]);
    end

    refmon_sticky #(.W(N_REF)) u_chg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (chg_evt),
        .clr_i (chg_clr_i),
        .flag_o(chg_flag_o)
    );

    refmon_sticky #(.W(1)) u_fail (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (fail_evt),
        .clr_i (fail_clr_i),
        .flag_o(fail_flag_v)
    );

    // R5
    fail_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fail_flag_v[0]) |-> $past(sel_valid_q));

    assign valid_o     = st_q.valid;
    assign fail_flag_o = fail_flag_v[0];
    assign irq_o       = (|(chg_flag_o & chg_mask_i)) | (fail_flag_v[0] & fail_mask_i);
    assign stat_pin_o  = pin_route_en_i & fail_mask_i & fail_flag_v[0];
endmodule

// File: tb/sim_refclk_health_mon.sv
`timescale 1ns/1ps
module sim_refclk_health_mon;
    localparam int unsigned N  = 4;
    localparam int unsigned MW = 3;
    localparam int unsigned IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] na = '0, fr = '0, ph = '0, nv = '0;
    logic [MW-1:0] miss = '0;
    logic ne = 1'b0, fe = 1'b0;
    logic [IW-1:0] sel = '0;
    logic [N-1:0] cmask = '0, cclr = '0;
    logic fmask = 1'b0, route = 1'b0, fclr = 1'b0;
    logic [N-1:0] valid, chg;
    logic fail, irq, pin;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    refclk_health_mon #(.N_REF(N), .MISS_W(MW), .IDX_W(IW)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .noact_alarm_i(na), .freq_alarm_i(fr), .phase_alarm_i(ph), .noise_viol_i(nv),
        .miss_cnt_i(miss), .noise_chk_en_i(ne), .fast_sw_en_i(fe), .sel_idx_i(sel),
        .chg_mask_i(cmask), .fail_mask_i(fmask), .pin_route_en_i(route),
        .chg_clr_i(cclr), .fail_clr_i(fclr),
        .valid_o(valid), .chg_flag_o(chg), .fail_flag_o(fail), .irq_o(irq), .stat_pin_o(pin)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        cclr = '1; fclr = 1'b1;
        tick();
        cclr = '0; fclr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9 reset state, even with every enable set
        cmask = '1; fmask = 1'b1; route = 1'b1;
        repeat (3) tick();
        chk("R9 valid", valid, 0);
        chk("R9 chg", chg, 0);
        chk("R9 fail", fail, 0);
        chk("R9 irq", irq, 0);
        chk("R9 pin", pin, 0);
        cmask = '0; fmask = 1'b0; route = 1'b0;
        rst_n = 1'b1;
        tick();
        chk("R9 first qualify valid", valid, 4'hF);
        chk("R9 first qualify chg", chg, 4'hF);
        chk("R5 recovery no fail", fail, 0);
        clear_all();
        chk("R4 clear", chg, 0);

        // R1/R2 sweep on input 2
        for (int c = 0; c < 32; c++) begin
            logic e;
            na[2] = c[0]; fr[2] = c[1]; ph[2] = c[2]; nv[2] = c[3]; ne = c[4];
            e = !(c[0] | c[1] | c[2] | (c[3] & c[4]));
            tick();
            chk(c[3] ? "R2 noise gate" : "R1 alarms", valid, {1'b1, e, 2'b11});
        end
        na = '0; fr = '0; ph = '0; nv = '0; ne = 1'b0;
        tick();
        clear_all();

        // R3 sweep: selected input 1
        sel = 2'd1;
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 4; m++) begin
                fe = en[0]; miss = MW'(m);
                tick();
                chk("R3 missed cycles", valid, {2'b11, !(en == 1 && m >= 2), 1'b1});
            end
        end
        fe = 1'b0; miss = '0; sel = 2'd0;
        tick();
        clear_all();

        // R4/R6 change flag
        ph[3] = 1'b1;
        tick();
        chk("R4 fall sets chg", chg, 4'h8);
        chk("R6 unmasked irq", irq, 0);
        cmask = 4'h4; #1;
        chk("R6 other mask", irq, 0);
        cmask = 4'h8; #1;
        chk("R6 masked irq", irq, 1);
        tick(); tick();
        chk("R4 sticky", chg, 4'h8);
        cclr = 4'h8;
        tick();
        cclr = '0;
        chk("R4 w1c", chg, 0);
        chk("R6 irq drop", irq, 0);
        ph[3] = 1'b0;
        tick();
        chk("R4 rise sets chg", chg, 4'h8);
        cmask = '0;
        clear_all();

        // R5/R6 failure flag
        sel = 2'd2; fmask = 1'b1;
        ph[0] = 1'b1;
        tick();
        chk("R5 other input", fail, 0);
        ph[2] = 1'b1;
        tick();
        chk("R5 selected falls", fail, 1);
        chk("R6 fail irq", irq, 1);
        chk("R7 route off", pin, 0);
        ph = '0; fclr = 1'b1;
        tick();
        fclr = 1'b0;
        chk("R5 recovery no fail", fail, 0);

        // R7 status pin
        route = 1'b1; ph[2] = 1'b1;
        tick();
        chk("R7 pin high", pin, 1);
        tick(); tick(); tick();
        chk("R7 pin holds", pin, 1);
        fmask = 1'b0; #1;
        chk("R7 pin masked", pin, 0);
        fmask = 1'b1; route = 1'b0; #1;
        chk("R7 route off", pin, 0);
        route = 1'b1; fclr = 1'b1;
        tick();
        fclr = 1'b0;
        chk("R7 pin cleared", pin, 0);

        // R8 event wins over clear
        ph[2] = 1'b0;
        tick();
        clear_all();
        ph[2] = 1'b1; fclr = 1'b1; cclr = 4'h4;
        tick();
        fclr = 1'b0; cclr = '0;
        chk("R8 fail event wins", fail, 1);
        chk("R8 chg event wins", chg, 4'h4);
        ph[2] = 1'b0;
        tick();
        clear_all();
        chk("R4 final clear", chg, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule